// File: doc/BRIEF.md
# Secure-side security configuration register file

This block is a 4 KB register window on a simple 32-bit peripheral bus that only the secure side of the chip can reach. It stores the permission masks that the peripheral protection controllers apply to their ports and drives every stored bit onto output wires. For each port it keeps a non-secure mask and a secure-privileged mask. The controllers fall into three groups: two internal APB controllers, four AHB expansion controllers and four APB expansion controllers. The block also holds a one-bit security response setting and a two-bit non-secure-callable setting, and it offers twelve read-only identification words. The per-port gating, the interrupt aggregation and the non-secure mirror of these registers are separate neighbours. They take the output wires of this block.

Each controller group occupies a 16-byte window, and address bits [3:2] pick the controller inside that window. The secure-privileged windows use the same layout as the non-secure windows, 0x40 bytes higher. Every stored mask is cut down to the port count of its controller. A write narrower than a word is dropped without any error. A read of any width returns the addressed byte lanes of the word.

Each bus request is handled by a two-state machine. In state IDLE, a request with `valid` high is accepted; the write is committed and the response is captured (transition IDLE->ACK). In state ACK, `ready` is high for exactly one cycle together with `rdata` and `err`, and the machine then returns to IDLE (transition ACK->IDLE). If `valid` is low, IDLE stays in IDLE (transition IDLE->IDLE).

Top module: `secctl_regs`

## Requirements
- R1: After reset, all permission masks, `resp_cfg_o` and `nsc_cfg_o` are zero, and `ready` and `err` are low.
- R2: A request seen with `valid` high in IDLE produces `ready` high in the following cycle, for one cycle only. `ready` is low in the cycle after that. A request that is still held while `ready` is high is not accepted again.
- R3: Offset 0x10 holds the security response setting. A word write stores bit 0, which drives `resp_cfg_o`. A read returns that bit in bit 0 and zero in bits [31:1].
- R4: Offset 0x14 holds the non-secure-callable setting. A word write stores wdata[1:0], which drive `nsc_cfg_o`. A read returns them in bits [1:0] and zero above.
- R5: The non-secure masks are at 0x60/0x64/0x68/0x6C (AHB expansion 0-3), 0x70/0x74 (APB internal 0-1) and 0x80/0x84/0x88/0x8C (APB expansion 0-3). addr[3:2] is the controller index. Offsets 0x78 and 0x7C are unmapped.
- R6: The secure-privileged masks are at the R5 offsets plus 0x40 (0xA0-0xAC, 0xB0/0xB4, 0xC0-0xCC). Writing them leaves the non-secure masks unchanged.
- R7: A written mask is ANDed with ((1<<ports)-1) before it is stored. The port counts are 3 for APB internal 0, 1 for APB internal 1 and 16 for every expansion controller. A read returns the stored value, zero-extended.
- R8: A write of size 0 (byte) or 1 (halfword) to any offset changes no state and answers with `err` low.
- R9: A read of size 0, 1 or 2 (word) returns the word shifted right by addr[1:0]*8 and then cut to 8, 16 or 32 bits.
- R10: Offsets 0xFD0 to 0xFFC are twelve read-only identification words. Each returns one byte in bits [7:0], in ascending address order 02 00 00 00 6A 91 1C 00 3C A5 5A C3. A word write there sets `err` and changes nothing.
- R11: A read of an unmapped offset returns `rdata` = 0 with `err` high. A word write to an unmapped offset sets `err` and changes nothing. `err` is high only in the cycle in which `ready` is high.
- R12: Size code 3 is reserved. Such a read or write sets `err`, returns `rdata` = 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Request valid |
| write | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address inside the window |
| wdata | input | 32 | Write data |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| ready | output | 1 | Response strobe, one cycle |
| rdata | output | 32 | Read data, valid with ready |
| err | output | 1 | Error response, valid with ready |
| resp_cfg_o | output | 1 | Security response setting |
| nsc_cfg_o | output | 2 | Non-secure-callable setting |
| apb_ns_o | output | 2x16 | Non-secure masks, APB internal controllers |
| apb_sp_o | output | 2x16 | Secure-privileged masks, APB internal controllers |
| ahbx_ns_o | output | 4x16 | Non-secure masks, AHB expansion controllers |
| ahbx_sp_o | output | 4x16 | Secure-privileged masks, AHB expansion controllers |
| apbx_ns_o | output | 4x16 | Non-secure masks, APB expansion controllers |
| apbx_sp_o | output | 4x16 | Secure-privileged masks, APB expansion controllers |

## Verification
Every stored bit is wired straight to an output, so an index that is decoded wrong, or a side swapped between non-secure and secure-privileged, shows up on the wrong output bus in the cycle after the accepting edge. The bench therefore looks at the output buses and also reads the value back. A bad port-count mask or a missed narrow-write drop leaves extra bits on a mask output at that same edge. A fault in the lane shifter or in the error decode only appears in the `rdata`/`err` sample taken while `ready` is high.

// File: rtl/secctl_pkg.sv
package secctl_pkg;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_RESP,
        TGT_NSC,
        TGT_NS_AHBX,
        TGT_NS_APB,
        TGT_NS_APBX,
        TGT_SP_AHBX,
        TGT_SP_APB,
        TGT_SP_APBX,
        TGT_ID
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [3:0] idx;
    } dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } st_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_RSVD = 2'd3;

    localparam int ID_WORDS = 12;

    function automatic logic [7:0] id_byte(input logic [3:0] i);
        case (i)
            4'd0:    id_byte = 8'h02;
            4'd4:    id_byte = 8'h6A;
            4'd5:    id_byte = 8'h91;
            4'd6:    id_byte = 8'h1C;
            4'd8:    id_byte = 8'h3C;
            4'd9:    id_byte = 8'hA5;
            4'd10:   id_byte = 8'h5A;
            4'd11:   id_byte = 8'hC3;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/secctl_decode.sv
module secctl_decode
    import secctl_pkg::*;
#(
    parameter int N_APB = 2,
    parameter int N_EXP = 4
) (
    input  logic [11:0] addr,
    output dec_t        dec
);
    logic [9:0] id_ofs;
    logic [1:0] sel;

    always_comb begin
        sel     = addr[3:2];
        id_ofs  = addr[11:2] - 10'h3F4;
        dec.tgt = TGT_NONE;
        dec.idx = {2'b00, sel};
        case (addr[11:4])
            8'h01: begin
                if (sel == 2'd0)      dec.tgt = TGT_RESP;
                else if (sel == 2'd1) dec.tgt = TGT_NSC;
            end
            8'h06: if (int'(sel) < N_EXP) dec.tgt = TGT_NS_AHBX;
            8'h07: if (int'(sel) < N_APB) dec.tgt = TGT_NS_APB;
            8'h08: if (int'(sel) < N_EXP) dec.tgt = TGT_NS_APBX;
            8'h0A: if (int'(sel) < N_EXP) dec.tgt = TGT_SP_AHBX;
            8'h0B: if (int'(sel) < N_APB) dec.tgt = TGT_SP_APB;
            8'h0C: if (int'(sel) < N_EXP) dec.tgt = TGT_SP_APBX;
            8'hFD, 8'hFE, 8'hFF: begin
                dec.tgt = TGT_ID;
                dec.idx = id_ofs[3:0];
            end
            default: dec.tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/secctl_mask_bank.sv
module secctl_mask_bank #(
    parameter int                    N_INST    = 4,
    parameter int                    MASK_W    = 16,
    parameter logic [N_INST*8-1:0]   PORT_CNTS = {N_INST{8'd16}}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_idx,
    input  logic [MASK_W-1:0]             wr_data,
    output logic [N_INST-1:0][MASK_W-1:0] q
);
    for (genvar g = 0; g < N_INST; g++) begin : g_inst
        localparam int CNT = int'(PORT_CNTS[g*8 +: 8]);
        localparam logic [MASK_W-1:0] KEEP =
            (CNT >= MASK_W) ? {MASK_W{1'b1}} : MASK_W'((64'd1 << CNT) - 64'd1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[g] <= '0;
            end else if (wr_en && (wr_idx == 2'(g))) begin
                q[g] <= wr_data & KEEP;
            end
        end
    end
endmodule

// File: rtl/secctl_rdlane.sv
module secctl_rdlane (
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    output logic [31:0] data
);
    logic [31:0] shifted;

    always_comb begin
        shifted = word >> {lane, 3'b000};
        case (size)
            2'd0:    data = {24'h0, shifted[7:0]};
            2'd1:    data = {16'h0, shifted[15:0]};
            default: data = shifted;
        endcase
    end
endmodule

// File: rtl/secctl_regs.sv
module secctl_regs
    import secctl_pkg::*;
#(
    parameter int MASK_W     = 16,
    parameter int N_EXP      = 4,
    parameter int APB0_PORTS = 3,
    parameter int APB1_PORTS = 1,
    parameter int EXP_PORTS  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid,
    input  logic                         write,
    input  logic [11:0]                  addr,
    input  logic [31:0]                  wdata,
    input  logic [1:0]                   size,
    output logic                         ready,
    output logic [31:0]                  rdata,
    output logic                         err,
    output logic                         resp_cfg_o,
    output logic [1:0]                   nsc_cfg_o,
    output logic [1:0][MASK_W-1:0]       apb_ns_o,
    output logic [1:0][MASK_W-1:0]       apb_sp_o,
    output logic [N_EXP-1:0][MASK_W-1:0] ahbx_ns_o,
    output logic [N_EXP-1:0][MASK_W-1:0] ahbx_sp_o,
    output logic [N_EXP-1:0][MASK_W-1:0] apbx_ns_o,
    output logic [N_EXP-1:0][MASK_W-1:0] apbx_sp_o
);
    localparam int N_APB = 2;
    localparam logic [N_APB*8-1:0] APB_CNTS = {8'(APB1_PORTS), 8'(APB0_PORTS)};
    localparam logic [N_EXP*8-1:0] EXP_CNTS = {N_EXP{8'(EXP_PORTS)}};

    st_e         state, state_nx;
    dec_t        dec;
    logic        accept;
    logic        wr_commit;
    logic        rd_err, wr_err;
    logic [31:0] word, lane_data;
    logic [31:0] rdata_q;
    logic        err_q;
    logic        resp_q;
    logic [1:0]  nsc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (valid) state_nx = ST_ACK;
            ST_ACK:  state_nx = ST_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        ready  = 1'b0;
        accept = 1'b0;
        unique case (state)
            ST_IDLE: accept = valid;
            ST_ACK:  ready  = 1'b1;
        endcase
    end

    secctl_decode #(.N_APB(N_APB), .N_EXP(N_EXP)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    always_comb begin
        rd_err    = (dec.tgt == TGT_NONE) || (size == SZ_RSVD);
        wr_err    = (dec.tgt == TGT_NONE) || (dec.tgt == TGT_ID) || (size == SZ_RSVD);
        wr_commit = accept && write && (size == SZ_WORD) && !wr_err;
    end

    secctl_mask_bank #(.N_INST(N_APB), .MASK_W(MASK_W), .PORT_CNTS(APB_CNTS)) u_ns_apb (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_commit && dec.tgt == TGT_NS_APB), .wr_idx(dec.idx[1:0]),
        .wr_data(wdata[MASK_W-1:0]), .q(apb_ns_o)
    );
    secctl_mask_bank #(.N_INST(N_APB), .MASK_W(MASK_W), .PORT_CNTS(APB_CNTS)) u_sp_apb (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_commit && dec.tgt == TGT_SP_APB), .wr_idx(dec.idx[1:0]),
        .wr_data(wdata[MASK_W-1:0]), .q(apb_sp_o)
    );
    secctl_mask_bank #(.N_INST(N_EXP), .MASK_W(MASK_W), .PORT_CNTS(EXP_CNTS)) u_ns_ahbx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_commit && dec.tgt == TGT_NS_AHBX), .wr_idx(dec.idx[1:0]),
        .wr_data(wdata[MASK_W-1:0]), .q(ahbx_ns_o)
    );
    secctl_mask_bank #(.N_INST(N_EXP), .MASK_W(MASK_W), .PORT_CNTS(EXP_CNTS)) u_sp_ahbx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_commit && dec.tgt == TGT_SP_AHBX), .wr_idx(dec.idx[1:0]),
        .wr_data(wdata[MASK_W-1:0]), .q(ahbx_sp_o)
    );
    secctl_mask_bank #(.N_INST(N_EXP), .MASK_W(MASK_W), .PORT_CNTS(EXP_CNTS)) u_ns_apbx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_commit && dec.tgt == TGT_NS_APBX), .wr_idx(dec.idx[1:0]),
        .wr_data(wdata[MASK_W-1:0]), .q(apbx_ns_o)
    );
    secctl_mask_bank #(.N_INST(N_EXP), .MASK_W(MASK_W), .PORT_CNTS(EXP_CNTS)) u_sp_apbx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_commit && dec.tgt == TGT_SP_APBX), .wr_idx(dec.idx[1:0]),
        .wr_data(wdata[MASK_W-1:0]), .q(apbx_sp_o)
    );

    // scalar settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= 1'b0;
            nsc_q  <= 2'b00;
        end else if (wr_commit) begin
            if (dec.tgt == TGT_RESP) resp_q <= wdata[0];
            if (dec.tgt == TGT_NSC)  nsc_q  <= wdata[1:0];
        end
    end

    assign resp_cfg_o = resp_q;
    assign nsc_cfg_o  = nsc_q;

    // read word selection
    always_comb begin
        word = '0;
        case (dec.tgt)
            TGT_RESP: word[0]   = resp_q;
            TGT_NSC:  word[1:0] = nsc_q;
            TGT_ID:   word[7:0] = id_byte(dec.idx);
            TGT_NS_APB, TGT_SP_APB: begin
                for (int i = 0; i < N_APB; i++) begin
                    if (int'(dec.idx) == i) begin
                        word[MASK_W-1:0] = (dec.tgt == TGT_NS_APB) ? apb_ns_o[i] : apb_sp_o[i];
                    end
                end
            end
            TGT_NS_AHBX, TGT_SP_AHBX: begin
                for (int i = 0; i < N_EXP; i++) begin
                    if (int'(dec.idx) == i) begin
                        word[MASK_W-1:0] = (dec.tgt == TGT_NS_AHBX) ? ahbx_ns_o[i] : ahbx_sp_o[i];
                    end
                end
            end
            TGT_NS_APBX, TGT_SP_APBX: begin
                for (int i = 0; i < N_EXP; i++) begin
                    if (int'(dec.idx) == i) begin
                        word[MASK_W-1:0] = (dec.tgt == TGT_NS_APBX) ? apbx_ns_o[i] : apbx_sp_o[i];
                    end
                end
            end
            default: word = '0;
        endcase
    end

    secctl_rdlane u_lane (
        .word (word),
        .lane (addr[1:0]),
        .size (size),
        .data (lane_data)
    );

    // response capture on IDLE->ACK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            if (write) begin
                rdata_q <= '0;
                err_q   <= (size == SZ_BYTE || size == SZ_HALF) ? 1'b0 : wr_err;
            end else begin
                rdata_q <= rd_err ? 32'h0 : lane_data;
                err_q   <= rd_err;
            end
        end
    end

    assign rdata = ready ? rdata_q : 32'h0;
    assign err   = ready & err_q;

endmodule

// File: rtl/secctl_regs_chk.sv
module secctl_regs_chk #(
    parameter int MASK_W     = 16,
    parameter int N_EXP      = 4,
    parameter int APB0_PORTS = 3,
    parameter int CFG_W      = 3 + (4 + 4 * N_EXP) * MASK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic              write,
    input logic [11:0]       addr,
    input logic [31:0]       wdata,
    input logic [1:0]        size,
    input logic              ready,
    input logic [31:0]       rdata,
    input logic              err,
    input logic [1:0]        nsc_cfg_o,
    input logic [MASK_W-1:0] apb0_ns,
    input logic [CFG_W-1:0]  cfg_all
);
    localparam logic [MASK_W-1:0] APB0_KEEP =
        (APB0_PORTS >= MASK_W) ? {MASK_W{1'b1}} : MASK_W'((64'd1 << APB0_PORTS) - 64'd1);

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R2
    AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> ready); // R2
    AST_NSC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && write && size == 2'd2 && addr == 12'h014) |=> nsc_cfg_o == $past(wdata[1:0])); // R4
    AST_APB0_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (apb0_ns & ~APB0_KEEP) == '0); // R7
    AST_NARROW_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && write && size < 2'd2) |=> $stable(cfg_all)); // R8
    AST_NARROW_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && write && size < 2'd2) |=> !err); // R8
    AST_RO_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && write && addr[11:4] >= 8'hFD) |=> $stable(cfg_all)); // R10
    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ready); // R11
    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rdata == 32'h0); // R12

endmodule

bind secctl_regs secctl_regs_chk #(
    .MASK_W(MASK_W), .N_EXP(N_EXP), .APB0_PORTS(APB0_PORTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid(valid), .write(write), .addr(addr),
    .wdata(wdata), .size(size), .ready(ready), .rdata(rdata), .err(err),
    .nsc_cfg_o(nsc_cfg_o), .apb0_ns(apb_ns_o[0]),
    .cfg_all({resp_cfg_o, nsc_cfg_o, apb_ns_o, apb_sp_o, ahbx_ns_o, ahbx_sp_o, apbx_ns_o, apbx_sp_o})
);

// File: tb/secctl_regs_bench.sv
module secctl_regs_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid = 1'b0;
    logic              write = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [1:0]        size = 2'd2;
    logic              ready;
    logic [31:0]       rdata;
    logic              err;
    logic              resp_cfg_o;
    logic [1:0]        nsc_cfg_o;
    logic [1:0][15:0]  apb_ns_o, apb_sp_o;
    logic [3:0][15:0]  ahbx_ns_o, ahbx_sp_o, apbx_ns_o, apbx_sp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    secctl_regs u_secctl_regs (
        .clk(clk), .rst_n(rst_n), .valid(valid), .write(write), .addr(addr),
        .wdata(wdata), .size(size), .ready(ready), .rdata(rdata), .err(err),
        .resp_cfg_o(resp_cfg_o), .nsc_cfg_o(nsc_cfg_o),
        .apb_ns_o(apb_ns_o), .apb_sp_o(apb_sp_o),
        .ahbx_ns_o(ahbx_ns_o), .ahbx_sp_o(ahbx_sp_o),
        .apbx_ns_o(apbx_ns_o), .apbx_sp_o(apbx_sp_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input logic [1:0] s, output logic [31:0] rd, output logic e);
        @(negedge clk);
        valid = 1'b1; write = w; addr = a; wdata = d; size = s;
        @(posedge clk); #1;
        rd = rdata; e = err;
        valid = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e);
        logic [31:0] rd;
        xfer(1'b1, a, d, 2'd2, rd, e);
    endtask

    task automatic rdw(input logic [11:0] a, input logic [1:0] s, output logic [31:0] rd, output logic e);
        xfer(1'b0, a, 32'h0, s, rd, e);
    endtask

    function automatic logic [63:0] all_cfg_nz();
        return 64'({resp_cfg_o, nsc_cfg_o, apb_ns_o, apb_sp_o, ahbx_ns_o,
                    ahbx_sp_o, apbx_ns_o, apbx_sp_o} != '0);
    endfunction

    task automatic t_reset();
        chk("R1 cfg zero", all_cfg_nz(), 0);
        chk("R1 ready", 64'(ready), 0);
        chk("R1 err", 64'(err), 0);
    endtask

    task automatic t_handshake();
        @(negedge clk);
        valid = 1'b1; write = 1'b0; addr = 12'h010; size = 2'd2;
        #1 chk("R2 no ready before edge", 64'(ready), 0);
        @(posedge clk); #1;
        chk("R2 ready", 64'(ready), 1);
        @(posedge clk); #1;
        chk("R2 ready one cycle", 64'(ready), 0);
        valid = 1'b0;
        @(posedge clk); #1;
        chk("R2 held request not re-accepted", 64'(ready), 0);
    endtask

    task automatic t_resp();
        logic [31:0] rd; logic e;
        wr(12'h010, 32'hFFFF_FFFF, e);
        chk("R3 write err", 64'(e), 0);
        chk("R3 resp out", 64'(resp_cfg_o), 1);
        rdw(12'h010, 2'd2, rd, e);
        chk("R3 readback", 64'(rd), 1);
        wr(12'h010, 32'h0000_0002, e);
        chk("R3 bit0 only", 64'(resp_cfg_o), 0);
    endtask

    task automatic t_nsc();
        logic [31:0] rd; logic e;
        wr(12'h014, 32'hFFFF_FFFE, e);
        chk("R4 nsc out", 64'(nsc_cfg_o), 2);
        rdw(12'h014, 2'd2, rd, e);
        chk("R4 readback", 64'(rd), 2);
    endtask

    task automatic t_ns_groups();
        logic [31:0] rd; logic e;
        for (int k = 0; k < 4; k++) begin
            wr(12'h060 + 12'(4 * k), 32'hABC0_0000 | 32'(16'h1100 + k), e);
            chk("R5 ahbx ns out", 64'(ahbx_ns_o[k]), 64'(16'h1100 + k));
            rdw(12'h060 + 12'(4 * k), 2'd2, rd, e);
            chk("R5 ahbx ns read", 64'(rd), 64'(16'h1100 + k));
        end
        wr(12'h070, 32'h0000_FFFF, e);
        chk("R7 apb0 masked to 3 ports", 64'(apb_ns_o[0]), 64'h7);
        wr(12'h074, 32'h0000_FFFF, e);
        chk("R7 apb1 masked to 1 port", 64'(apb_ns_o[1]), 64'h1);
        rdw(12'h070, 2'd2, rd, e);
        chk("R7 apb0 readback", 64'(rd), 64'h7);
        wr(12'h084, 32'h1234_F00F, e);
        chk("R5 apbx1 ns out", 64'(apbx_ns_o[1]), 64'hF00F);
        chk("R5 apbx others", 64'({apbx_ns_o[3], apbx_ns_o[2], apbx_ns_o[0]}), 0);
    endtask

    task automatic t_sp_groups();
        logic [31:0] rd; logic e;
        wr(12'h0A4, 32'h0000_5555, e);
        chk("R6 ahbx sp1 out", 64'(ahbx_sp_o[1]), 64'h5555);
        chk("R6 ahbx ns1 unchanged", 64'(ahbx_ns_o[1]), 64'h1101);
        wr(12'h0B0, 32'h0000_FFFF, e);
        chk("R6 apb sp0 masked", 64'(apb_sp_o[0]), 64'h7);
        chk("R6 apb ns0 unchanged", 64'(apb_ns_o[0]), 64'h7);
        wr(12'h0CC, 32'h0000_8001, e);
        chk("R6 apbx sp3 out", 64'(apbx_sp_o[3]), 64'h8001);
        rdw(12'h0CC, 2'd2, rd, e);
        chk("R6 apbx sp3 read", 64'(rd), 64'h8001);
    endtask

    task automatic t_narrow();
        logic [31:0] rd; logic e;
        xfer(1'b1, 12'h070, 32'h0, 2'd0, rd, e);
        chk("R8 byte write err", 64'(e), 0);
        chk("R8 byte write dropped", 64'(apb_ns_o[0]), 64'h7);
        xfer(1'b1, 12'h014, 32'h0, 2'd1, rd, e);
        chk("R8 half write dropped", 64'(nsc_cfg_o), 2);
    endtask

    task automatic t_lanes();
        logic [31:0] rd; logic e;
        wr(12'h060, 32'h0000_1234, e);
        rdw(12'h061, 2'd0, rd, e);
        chk("R9 byte lane1", 64'(rd), 64'h12);
        rdw(12'h060, 2'd0, rd, e);
        chk("R9 byte lane0", 64'(rd), 64'h34);
        rdw(12'h060, 2'd1, rd, e);
        chk("R9 half lane0", 64'(rd), 64'h1234);
        rdw(12'h063, 2'd0, rd, e);
        chk("R9 byte lane3", 64'(rd), 64'h0);
        rdw(12'h061, 2'd1, rd, e);
        chk("R9 half lane1", 64'(rd), 64'h12);
    endtask

    task automatic t_id();
        logic [31:0] rd; logic e;
        logic [7:0] exp_id [12] = '{8'h02, 8'h00, 8'h00, 8'h00, 8'h6A, 8'h91,
                                    8'h1C, 8'h00, 8'h3C, 8'hA5, 8'h5A, 8'hC3};
        for (int k = 0; k < 12; k++) begin
            rdw(12'hFD0 + 12'(4 * k), 2'd2, rd, e);
            chk("R10 id byte", 64'(rd), 64'(exp_id[k]));
            chk("R10 id err", 64'(e), 0);
        end
        wr(12'hFD0, 32'hFFFF_FFFF, e);
        chk("R10 id write err", 64'(e), 1);
        rdw(12'hFD0, 2'd2, rd, e);
        chk("R10 id unchanged", 64'(rd), 64'h02);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; logic e;
        rdw(12'h078, 2'd2, rd, e);
        chk("R11 read 0x78 err", 64'(e), 1);
        chk("R11 read 0x78 data", 64'(rd), 0);
        rdw(12'h200, 2'd2, rd, e);
        chk("R11 read 0x200 err", 64'(e), 1);
        wr(12'h07C, 32'hFFFF_FFFF, e);
        chk("R11 write 0x7C err", 64'(e), 1);
        chk("R11 apb unchanged", 64'(apb_ns_o), 64'({16'h1, 16'h7}));
        @(negedge clk);
        chk("R11 err gone after ready", 64'(err), 0);
    endtask

    task automatic t_size3();
        logic [31:0] rd; logic e;
        xfer(1'b1, 12'h014, 32'h0, 2'd3, rd, e);
        chk("R12 write err", 64'(e), 1);
        chk("R12 nsc unchanged", 64'(nsc_cfg_o), 2);
        xfer(1'b0, 12'h014, 32'h0, 2'd3, rd, e);
        chk("R12 read err", 64'(e), 1);
        chk("R12 read data", 64'(rd), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_handshake();
        t_resp();
        t_nsc();
        t_ns_groups();
        t_sp_groups();
        t_narrow();
        t_lanes();
        t_id();
        t_unmapped();
        t_size3();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule